// File: doc/BRIEF.md
# Serial Receive Fall-Through Buffer

This block is the receive data path of one serial channel. Strobed serial bits are assembled into a byte, least significant bit first, by a deserializer. Each completed byte drops into a chain of three byte stages. A byte moves up one stage per clock edge whenever the stage above it is empty or is being emptied in the same cycle. The topmost stage is the receive buffer that the host sees. Reading that stage lets the byte below it move up.

The deserializer and the three stages together hold up to four bytes. A byte can finish while the bottom stage is still occupied. When that happens, the new byte is discarded and a sticky overrun flag is raised. The flag stays set until a dedicated clear strobe is applied. Framing, parity and bit-clock recovery belong to other logic.

Top module: `rx_fall_chain`

## Requirements
- R1: After reset, `avail_o` is 0, `ovr_o` is 0 and `data_o` is 8'h00.
- R2: Bits are taken from `bit_i` only in cycles where `bit_stb_i` is 1. The first bit taken becomes bit 0 of the byte and the eighth becomes bit 7. `bit_i` has no effect in cycles without the strobe.
- R3: With all stages empty, a byte completes at the clock edge that samples its eighth bit. `avail_o` then rises two clock edges later.
- R4: Bytes are delivered at `data_o` in the order they completed, and up to three of them are held without loss.
- R5: `avail_o` is 1 exactly when the top stage holds a byte. While `rd_i` is 0, that byte and `avail_o` stay unchanged.
- R6: A read (`rd_i` = 1 with `avail_o` = 1) removes the top byte at that clock edge. If the stage below holds a byte, that byte is in the top stage after the same edge, so `avail_o` stays 1.
- R7: A byte that completes while the bottom stage is occupied and cannot move up is discarded, and `ovr_o` is set. `ovr_o` stays set until it is cleared.
- R8: `ovr_clr_i` clears `ovr_o` at the next edge. If a new overrun occurs in the same cycle as the clear, `ovr_o` stays 1.
- R9: With three bytes stored, a fourth byte being assembled is kept without overrun if a read frees space before its eighth bit arrives.
- R10: `rd_i` while `avail_o` is 0 has no effect on later data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial data bit |
| bit_stb_i | input | 1 | Sample strobe for `bit_i` |
| rd_i | input | 1 | Host read of the top stage |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| data_o | output | 8 | Byte in the top stage |
| avail_o | output | 1 | Top stage holds a byte |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
The hardest case to reach is the fourth level of buffering. All three stages must be full while the deserializer is partway through another byte, and the read that frees space must land before that byte's last bit. The stimulus first loads three bytes and lets them settle, then sends seven bits of a fourth byte. It then issues one read, sends the eighth bit, and confirms that no overrun occurs and that all four bytes come out in order. A variant applies the overrun clear in the same cycle as an overflowing eighth bit, to show that setting the flag takes priority.

// File: rtl/rx_chain_pkg.sv
package rx_chain_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned N_STG  = 3;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/rx_deser.sv
module rx_deser #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_i,
  input  logic         stb_i,
  output logic         done_o,
  output logic [W-1:0] word_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == CW'(W-1));
  assign done_o = stb_i & last;
  assign word_o = {bit_i, sr_q[W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (stb_i) begin
      sr_q  <= {bit_i, sr_q[W-1:1]};
      cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rx_stage.sv
module rx_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  input  logic         leave_i,
  output logic         vld_o,
  output logic [W-1:0] dout_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      dout_o <= '0;
    end else if (load_i) begin
      vld_o  <= 1'b1;
      dout_o <= din_i;
    end else if (leave_i) begin
      vld_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_fall_chain.sv
module rx_fall_chain
  import rx_chain_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              bit_stb_i,
  input  logic              rd_i,
  input  logic              ovr_clr_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              avail_o,
  output logic              ovr_o
);
  localparam int unsigned TOP = N_STG - 1;

  logic                          done;
  byte_t                         word;
  logic [N_STG-1:0]              stage_vld;
  logic [N_STG-1:0][BYTE_W-1:0]  stage_dat;
  logic [N_STG-1:0]              leave;
  logic [N_STG-1:0]              load;
  logic                          ovr_set;

  rx_deser #(.W(BYTE_W)) u_deser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (bit_i),
    .stb_i  (bit_stb_i),
    .done_o (done),
    .word_o (word)
  );

  // leave ripples top-down: a stage empties if the one above can take it
  always_comb begin
    leave[TOP] = rd_i & stage_vld[TOP];
    for (int i = TOP - 1; i >= 0; i--) begin
      leave[i] = stage_vld[i] & (~stage_vld[i+1] | leave[i+1]);
    end
  end

  assign load[0] = done & (~stage_vld[0] | leave[0]);
  assign ovr_set = done & stage_vld[0] & ~leave[0];

  for (genvar g = 0; g < N_STG; g++) begin : g_stg
    if (g == 0) begin : g_bot
      rx_stage #(.W(BYTE_W)) u_stage (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load[0]),
        .din_i   (word),
        .leave_i (leave[0]),
        .vld_o   (stage_vld[0]),
        .dout_o  (stage_dat[0])
      );
    end else begin : g_up
      assign load[g] = leave[g-1];
      rx_stage #(.W(BYTE_W)) u_stage (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load[g]),
        .din_i   (stage_dat[g-1]),
        .leave_i (leave[g]),
        .vld_o   (stage_vld[g]),
        .dout_o  (stage_dat[g])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovr_o <= 1'b0;
    else if (ovr_set)   ovr_o <= 1'b1;
    else if (ovr_clr_i) ovr_o <= 1'b0;
  end

  assign data_o  = stage_dat[TOP];
  assign avail_o = stage_vld[TOP];
endmodule

// File: rtl/rx_fall_chain_chk.sv
module rx_fall_chain_chk #(
  parameter int unsigned N = 3,
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         bit_stb_i,
  input logic         rd_i,
  input logic         ovr_clr_i,
  input logic [W-1:0] data_o,
  input logic         avail_o,
  input logic         ovr_o,
  input logic [N-1:0] stage_vld
);
  AST_TOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail_o && !rd_i |=> avail_o && $stable(data_o)); // R5

  AST_READ_REFILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && stage_vld[N-1] && stage_vld[N-2] |=> avail_o); // R6

  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o && !ovr_clr_i |=> ovr_o); // R7

  AST_NO_SPURIOUS_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovr_o && (!bit_stb_i || !stage_vld[0]) |=> !ovr_o); // R7

  AST_OVR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_clr_i && !bit_stb_i |=> !ovr_o); // R8

  AST_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !avail_o && rd_i && !stage_vld[N-2] |=> !avail_o); // R10
endmodule

bind rx_fall_chain rx_fall_chain_chk #(
  .N(rx_chain_pkg::N_STG),
  .W(rx_chain_pkg::BYTE_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bit_stb_i (bit_stb_i),
  .rd_i      (rd_i),
  .ovr_clr_i (ovr_clr_i),
  .data_o    (data_o),
  .avail_o   (avail_o),
  .ovr_o     (ovr_o),
  .stage_vld (stage_vld)
);

// File: tb/sim_rx_fall_chain.sv
module sim_rx_fall_chain;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_i = 1'b0;
  logic       stb = 1'b0;
  logic       rd = 1'b0;
  logic       clr = 1'b0;
  logic [7:0] data;
  logic       avail;
  logic       ovr;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  rx_fall_chain u0 (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_i), .bit_stb_i(stb),
    .rd_i(rd), .ovr_clr_i(clr), .data_o(data), .avail_o(avail), .ovr_o(ovr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one strobed bit; bit_i is flipped in the idle cycle to show it is ignored (R2)
  task automatic put_bit(input logic b, input logic with_clr = 1'b0);
    @(negedge clk); bit_i = b; stb = 1'b1; clr = with_clr;
    @(negedge clk); stb = 1'b0; clr = 1'b0; bit_i = ~b;
  endtask

  // driver: sends bits [0..n-1], pushes expected byte when it is to be kept
  task automatic send(input logic [7:0] v, input int n, input bit keep);
    for (int i = 0; i < n; i++) put_bit(v[i]);
    if (keep && n == 8) exp_q.push_back(v);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops the scoreboard and compares against the top stage, then reads
  task automatic pop(input string req);
    logic [7:0] e;
    @(negedge clk);
    check(avail === 1'b1, {req, " avail"}, avail, 1);
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
    check(data === e, {req, " data"}, data, e);
    rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check(avail === 1'b0, "R1 avail", avail, 0);
    check(ovr === 1'b0, "R1 ovr", ovr, 0);
    check(data === 8'h00, "R1 data", data, 0);

    // R3 latency and R2 bit order
    send(8'h01, 7, 0);
    put_bit(1'b0);
    exp_q.push_back(8'h01);
    check(avail === 1'b0, "R3 bottom", avail, 0);
    @(posedge clk); #1;
    check(avail === 1'b0, "R3 middle", avail, 0);
    @(posedge clk); #1;
    check(avail === 1'b1, "R3 top", avail, 1);
    idle(3);
    check(avail === 1'b1 && data === 8'h01, "R5 hold", data, 8'h01);
    pop("R2 lsb first");
    idle(2);
    check(avail === 1'b0, "R5 empty after read", avail, 0);

    // R10 read while empty
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    send(8'h80, 8, 1);
    idle(4);
    pop("R10 after empty read");

    // R4 order, three held; R6 refill on read
    send(8'hA5, 8, 1);
    send(8'h3C, 8, 1);
    send(8'hF0, 8, 1);
    idle(4);
    check(ovr === 1'b0, "R4 no overrun", ovr, 0);
    pop("R4 first");
    check(avail === 1'b1, "R6 refill", avail, 1);
    pop("R4 second");
    pop("R4 third");
    idle(3);
    check(avail === 1'b0, "R4 drained", avail, 0);

    // R9 fourth level saved by a read before the last bit
    send(8'h11, 8, 1);
    send(8'h22, 8, 1);
    send(8'h33, 8, 1);
    idle(4);
    send(8'hC4, 7, 0);
    pop("R9 free slot");
    put_bit(1'b1);
    exp_q.push_back(8'hC4);
    check(ovr === 1'b0, "R9 no overrun", ovr, 0);
    idle(4);
    pop("R9 b");
    pop("R9 c");
    pop("R9 fourth");

    // R7 overrun: fourth byte lost, flag sticky
    send(8'h5A, 8, 1);
    send(8'h6B, 8, 1);
    send(8'h7C, 8, 1);
    idle(4);
    send(8'hEE, 8, 0);
    check(ovr === 1'b1, "R7 set", ovr, 1);
    idle(5);
    check(ovr === 1'b1, "R7 sticky", ovr, 1);
    pop("R7 a");
    pop("R7 b");
    pop("R7 c");
    idle(4);
    check(avail === 1'b0, "R7 dropped byte", avail, 0);

    // R8 clear
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check(ovr === 1'b0, "R8 clear", ovr, 0);

    // R8 set wins over clear in the same cycle
    send(8'h01, 8, 1);
    send(8'h02, 8, 1);
    send(8'h03, 8, 1);
    idle(4);
    send(8'h99, 7, 0);
    put_bit(1'b1, 1'b1);
    check(ovr === 1'b1, "R8 set wins", ovr, 1);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check(ovr === 1'b0, "R8 clear again", ovr, 0);
    pop("R8 a");
    pop("R8 b");
    pop("R8 c");
    check(exp_q.size() == 0, "R4 scoreboard empty", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule